// File: doc/BRIEF.md
# Fault-Hardened First-Stage Switch Allocator

This block runs the first stage of switch allocation in a five-port router with several virtual channels (VCs) per input. It also runs the second stage, one round-robin grant per output. Each input port normally picks one of its non-empty VCs with a round-robin arbiter and offers that nominee to the output stage. When the port's arbiter is flagged faulty, a per-port default-VC register takes its place. The default VC is then always the nominee. While the default VC is empty, the block instead orders flits to be moved into it from the port's other VCs.

Ports 0 and 1 form one pair, ports 2 and 3 the other, and port 4 is the local port. Each port owns one line into the output stage. A pair port whose line has failed can have its nominee carried on its partner's line. When both lines of a pair have failed, the local port's line can carry one nominee from that pair. Fault flags are static configuration, and every selection reacts to them only after they have been registered. All outputs are registered, so a result appears one clock after the request pattern that produced it.

Top module: `sa_fault_bypass`

## Requirements
- R1: While reset is held, and on the first edge after it, every output is zero. The VC round-robin pointers and the output round-robin pointers start at 0.
- R2: For a port whose registered arbiter fault flag is clear, the nominee is the first non-empty VC at or after the port's pointer, searching in ascending order with wrap-around. Request bit `p*NVC+v` marks VC v of port p as non-empty. The pointer moves to the VC after the granted one, and it moves only when that nominee is granted.
- R3: A port's default register loads `dflt_cfg[p*VCW +: VCW]` on every edge where the port's registered arbiter fault flag is clear. It holds its value on every edge where that flag is set.
- R4: For a port in bypass (registered arbiter fault flag set), the nominee is always the default VC, provided the default VC is non-empty.
- R5: A port in bypass whose default VC is empty, and which has another non-empty VC, raises `xfer_vld`. `xfer_src` is the lowest-numbered non-empty VC and `xfer_dst` is the default VC. The port makes no nomination in that cycle.
- R6: `arb_flt` and `line_flt` are registered before use. A flag changed before edge k first alters the outputs produced at edge k+1.
- R7: A pair port's line carries the port's own nominee. If the port has no nominee, the line carries the partner's nominee, but only when the partner's line is flagged faulty. A faulty line carries nothing.
- R8: If the local line is healthy, it carries a nominee in this order of precedence: the local port's own nominee first, then a nominee from pair 0/1 (lower port first) if both of that pair's lines are faulty, then one from pair 2/3 under the same condition. A faulty local line carries nothing.
- R9: A nominee requests the output given by `route[(p*NVC+v)*3 +: 3]`, where values 0 to 4 name outputs and higher values match no output. Each output grants at most one carried nominee per cycle. The search starts at the source port after the last one granted and wraps round-robin over ports 0 to 4. `out_src` reports the winning port.
- R10: `gnt_vld[p]` is set only for a nominated port. A grant taken through the default register leaves the port's VC pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 5*NVC | Non-empty flag per VC, bit p*NVC+v |
| route | input | 5*NVC*3 | Requested output per VC, field (p*NVC+v)*3 |
| dflt_cfg | input | 5*VCW | Default VC ID per port |
| arb_flt | input | 5 | Port VC arbiter flagged faulty |
| line_flt | input | 5 | Port line into the output stage flagged faulty |
| nom_vld | output | 5 | Port nominee carried this cycle |
| nom_vc | output | 5*VCW | Nominated VC per port, zero when none |
| gnt_vld | output | 5 | Port nominee granted an output |
| out_vld | output | 5 | Output granted to some port |
| out_src | output | 15 | Winning source port per output, zero when none |
| xfer_vld | output | 5 | Flit move into default VC ordered |
| xfer_src | output | 5*VCW | VC that gives up the flit |
| xfer_dst | output | 5*VCW | Default VC that receives the flit |

## Verification
Several properties are checked every cycle. A grant requires a nomination, and a transfer never coincides with a nomination. A bypass nominee and a transfer destination always equal the stored default. The default register stays frozen while its port is flagged. Failed lines never let nominations through, and every output winner is itself granted. Properties cannot show the round-robin order, the exact cycle when a flag takes hold, the choice of the partner or local line, or the choice of transfer source. Those come only from the bench's directed scenarios and its per-cycle reference model.

// File: rtl/sa_fault_bypass.sv
module sa_fault_bypass #(
  parameter int NVC = 4,
  localparam int VCW = $clog2(NVC),
  localparam int NP = 5,
  localparam int PW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NP*NVC-1:0] req,
  input  logic [NP*NVC*PW-1:0] route,
  input  logic [NP*VCW-1:0] dflt_cfg,
  input  logic [NP-1:0]     arb_flt,
  input  logic [NP-1:0]     line_flt,
  output logic [NP-1:0]     nom_vld,
  output logic [NP*VCW-1:0] nom_vc,
  output logic [NP-1:0]     gnt_vld,
  output logic [NP-1:0]     out_vld,
  output logic [NP*PW-1:0]  out_src,
  output logic [NP-1:0]     xfer_vld,
  output logic [NP*VCW-1:0] xfer_src,
  output logic [NP*VCW-1:0] xfer_dst
);

  logic [NP-1:0]     arb_q, line_q;
  logic [NP*VCW-1:0] dreg_q;
  logic [VCW-1:0]    ptr1_q [NP];
  logic [PW-1:0]     ptr2_q [NP];

  logic [NP-1:0]     cv, car, xv, gn, ov;
  logic [VCW-1:0]    cvc [NP];
  logic [VCW-1:0]    xs [NP];
  logic [VCW-1:0]    dflt [NP];
  logic [PW-1:0]     dst [NP];
  logic [PW-1:0]     os [NP];

  for (genvar g = 0; g < NP; g++) begin : g_port
    assign dflt[g] = dreg_q[g*VCW +: VCW];
    assign dst[g]  = route[(g*NVC + int'(cvc[g]))*PW +: PW];
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      cv[p]  = 1'b0;
      cvc[p] = '0;
      xv[p]  = 1'b0;
      xs[p]  = '0;
      if (arb_q[p]) begin
        if (req[p*NVC + int'(dflt[p])]) begin
          cv[p]  = 1'b1;
          cvc[p] = dflt[p];
        end else begin
          for (int v = NVC-1; v >= 0; v--)
            if (req[p*NVC + v]) begin
              xv[p] = 1'b1;
              xs[p] = VCW'(v);
            end
        end
      end else begin
        for (int k = NVC-1; k >= 0; k--)
          if (req[p*NVC + (int'(ptr1_q[p]) + k) % NVC]) begin
            cv[p]  = 1'b1;
            cvc[p] = VCW'((int'(ptr1_q[p]) + k) % NVC);
          end
      end
    end
  end

  always_comb begin
    car = '0;
    for (int p = 0; p < 4; p++)
      if (!line_q[p]) begin
        if (cv[p])                         car[p] = 1'b1;
        else if (cv[p^1] && line_q[p^1])   car[p^1] = 1'b1;
      end
    if (!line_q[4]) begin
      if (cv[4])                               car[4] = 1'b1;
      else if (&line_q[1:0] && |cv[1:0])       car[cv[0] ? 0 : 1] = 1'b1;
      else if (&line_q[3:2] && |cv[3:2])       car[cv[2] ? 2 : 3] = 1'b1;
    end
  end

  always_comb begin
    gn = '0;
    ov = '0;
    for (int o = 0; o < NP; o++) begin
      os[o] = '0;
      for (int k = NP-1; k >= 0; k--) begin
        int s;
        s = (int'(ptr2_q[o]) + k) % NP;
        if (car[s] && dst[s] == PW'(o)) begin
          ov[o] = 1'b1;
          os[o] = PW'(s);
        end
      end
      if (ov[o]) gn[os[o]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_q    <= '0;
      line_q   <= '0;
      dreg_q   <= '0;
      nom_vld  <= '0;
      nom_vc   <= '0;
      gnt_vld  <= '0;
      out_vld  <= '0;
      out_src  <= '0;
      xfer_vld <= '0;
      xfer_src <= '0;
      xfer_dst <= '0;
      for (int p = 0; p < NP; p++) begin
        ptr1_q[p] <= '0;
        ptr2_q[p] <= '0;
      end
    end else begin
      arb_q    <= arb_flt;
      line_q   <= line_flt;
      nom_vld  <= car;
      gnt_vld  <= gn;
      out_vld  <= ov;
      xfer_vld <= xv;
      for (int p = 0; p < NP; p++) begin
        if (!arb_q[p]) dreg_q[p*VCW +: VCW] <= dflt_cfg[p*VCW +: VCW];
        nom_vc[p*VCW +: VCW]   <= car[p] ? cvc[p] : '0;
        xfer_src[p*VCW +: VCW] <= xv[p] ? xs[p] : '0;
        xfer_dst[p*VCW +: VCW] <= xv[p] ? dflt[p] : '0;
        out_src[p*PW +: PW]    <= os[p];
        if (ov[p])
          ptr2_q[p] <= (os[p] == PW'(NP-1)) ? '0 : os[p] + PW'(1);
        if (gn[p] && !arb_q[p])
          ptr1_q[p] <= (cvc[p] == VCW'(NVC-1)) ? '0 : cvc[p] + VCW'(1);
      end
    end
  end

endmodule

// File: rtl/sa_fault_bypass_chk.sv
module sa_fault_bypass_chk #(
  parameter int NVC = 4,
  localparam int VCW = $clog2(NVC)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [4:0]     arb_q,
  input logic [4:0]     line_q,
  input logic [5*VCW-1:0] dreg_q,
  input logic [4:0]     nom_vld,
  input logic [5*VCW-1:0] nom_vc,
  input logic [4:0]     gnt_vld,
  input logic [4:0]     out_vld,
  input logic [14:0]    out_src,
  input logic [4:0]     xfer_vld,
  input logic [5*VCW-1:0] xfer_src,
  input logic [5*VCW-1:0] xfer_dst
);

  for (genvar p = 0; p < 5; p++) begin : g_chk
    AST_GNT_NEEDS_NOM: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[p] |-> nom_vld[p]); // R10
    AST_XFER_NO_NOM: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_vld[p] |-> !nom_vld[p]); // R5
    AST_XFER_TO_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_vld[p] |-> (xfer_dst[p*VCW +: VCW] == $past(dreg_q[p*VCW +: VCW]))
                      && (xfer_src[p*VCW +: VCW] != xfer_dst[p*VCW +: VCW])); // R5
    AST_BYPASS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (nom_vld[p] && $past(arb_q[p])) |-> nom_vc[p*VCW +: VCW] == $past(dreg_q[p*VCW +: VCW])); // R4
    AST_DEFAULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(arb_q[p]) |-> $stable(dreg_q[p*VCW +: VCW])); // R3
    AST_WINNER_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[p] |-> gnt_vld[out_src[p*3 +: 3]]); // R9
  end

  AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt_vld) == $countones(out_vld)); // R9
  AST_LOCAL_LINE_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_q[4]) |-> !nom_vld[4]); // R8
  AST_PAIR_CUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(&{line_q[4], line_q[1:0]}) |-> nom_vld[1:0] == 2'b00); // R7

endmodule

bind sa_fault_bypass sa_fault_bypass_chk #(.NVC(NVC)) u_chk (
  .clk(clk), .rst_n(rst_n), .arb_q(arb_q), .line_q(line_q), .dreg_q(dreg_q),
  .nom_vld(nom_vld), .nom_vc(nom_vc), .gnt_vld(gnt_vld), .out_vld(out_vld),
  .out_src(out_src), .xfer_vld(xfer_vld), .xfer_src(xfer_src), .xfer_dst(xfer_dst)
);

// File: tb/tb_sa_fault_bypass.sv
module tb_sa_fault_bypass;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [19:0] req = '0;
  logic [59:0] route = '0;
  logic [9:0]  dcfg = '0;
  logic [4:0]  aflt = '0, lflt = '0;
  logic [4:0]  nom_vld, gnt_vld, out_vld, xfer_vld;
  logic [9:0]  nom_vc, xfer_src, xfer_dst;
  logic [14:0] out_src;

  sa_fault_bypass dut (
    .clk(clk), .rst_n(rst_n), .req(req), .route(route), .dflt_cfg(dcfg),
    .arb_flt(aflt), .line_flt(lflt), .nom_vld(nom_vld), .nom_vc(nom_vc),
    .gnt_vld(gnt_vld), .out_vld(out_vld), .out_src(out_src),
    .xfer_vld(xfer_vld), .xfer_src(xfer_src), .xfer_dst(xfer_dst)
  );

  int total = 0, fails = 0;
  bit done = 0;
  string tag = "R2";

  int mp1[5], mp2[5], mdreg[5];
  bit maq[5], mlq[5];
  bit env[5], eg[5], eov[5], exv[5];
  int envc[5], eos[5], exs[5], exd[5];

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic mreset();
    for (int p = 0; p < 5; p++) begin
      mp1[p] = 0; mp2[p] = 0; mdreg[p] = 0; maq[p] = 0; mlq[p] = 0;
      env[p] = 0; eg[p] = 0; eov[p] = 0; exv[p] = 0;
      envc[p] = 0; eos[p] = 0; exs[p] = 0; exd[p] = 0;
    end
  endtask

  task automatic mstep();
    bit cv[5], car[5];
    int cvc[5];
    int src[$];
    for (int p = 0; p < 5; p++) begin
      cv[p] = 0; cvc[p] = 0; car[p] = 0; exv[p] = 0; exs[p] = 0; exd[p] = 0;
      if (maq[p]) begin
        if (req[p*4 + mdreg[p]]) begin cv[p] = 1; cvc[p] = mdreg[p]; end
        else for (int v = 0; v < 4; v++)
          if (req[p*4 + v] && !exv[p]) begin exv[p] = 1; exs[p] = v; exd[p] = mdreg[p]; end
      end else begin
        for (int k = 0; k < 4; k++)
          if (!cv[p] && req[p*4 + (mp1[p]+k)%4]) begin cv[p] = 1; cvc[p] = (mp1[p]+k)%4; end
      end
    end
    for (int p = 0; p < 4; p++) begin
      int q = (p % 2 == 0) ? p + 1 : p - 1;
      if (!mlq[p] && cv[p]) car[p] = 1;
      else if (!mlq[p] && cv[q] && mlq[q]) car[q] = 1;
    end
    if (!mlq[4]) begin
      src = {};
      if (cv[4]) src.push_back(4);
      if (mlq[0] && mlq[1]) begin if (cv[0]) src.push_back(0); else if (cv[1]) src.push_back(1); end
      if (mlq[2] && mlq[3]) begin if (cv[2]) src.push_back(2); else if (cv[3]) src.push_back(3); end
      if (src.size() > 0) car[src[0]] = 1;
    end
    for (int p = 0; p < 5; p++) begin
      env[p] = car[p]; envc[p] = car[p] ? cvc[p] : 0; eg[p] = 0;
    end
    for (int o = 0; o < 5; o++) begin
      eov[o] = 0; eos[o] = 0;
      for (int k = 0; k < 5; k++) begin
        int s = (mp2[o] + k) % 5;
        if (!eov[o] && car[s] && int'(route[(s*4 + cvc[s])*3 +: 3]) == o) begin
          eov[o] = 1; eos[o] = s;
        end
      end
      if (eov[o]) begin
        eg[eos[o]] = 1;
        mp2[o] = (eos[o] + 1) % 5;
        if (!maq[eos[o]]) mp1[eos[o]] = (cvc[eos[o]] + 1) % 4;
      end
    end
    for (int p = 0; p < 5; p++) begin
      if (!maq[p]) mdreg[p] = int'(dcfg[p*2 +: 2]);
      maq[p] = aflt[p];
      mlq[p] = lflt[p];
    end
  endtask

  task automatic compare();
    bit ok_n = 1, ok_g = 1, ok_o = 1, ok_x = 1;
    for (int p = 0; p < 5; p++) begin
      if (nom_vld[p] != env[p] || int'(nom_vc[p*2 +: 2]) != envc[p]) ok_n = 0;
      if (gnt_vld[p] != eg[p]) ok_g = 0;
      if (out_vld[p] != eov[p] || int'(out_src[p*3 +: 3]) != eos[p]) ok_o = 0;
      if (xfer_vld[p] != exv[p] || int'(xfer_src[p*2 +: 2]) != exs[p] ||
          int'(xfer_dst[p*2 +: 2]) != exd[p]) ok_x = 0;
    end
    chk(ok_n, tag, "nomination vs model", int'(nom_vc), envc[0]);
    chk(ok_g, "R10", "grant vs model", int'(gnt_vld), int'(eg[0]));
    chk(ok_o, "R9", "output grant vs model", int'(out_src), eos[0]);
    chk(ok_x, "R5", "transfer vs model", int'(xfer_src), exs[0]);
  endtask

  task automatic tick();
    if (rst_n) mstep(); else mreset();
    @(negedge clk);
    compare();
  endtask

  function automatic int nvc(int p); return int'(nom_vc[p*2 +: 2]); endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    mreset();
    tag = "R1";
    tick(); tick();
    chk({nom_vld, gnt_vld, out_vld, xfer_vld} == '0, "R1", "outputs in reset",
        int'({nom_vld, gnt_vld, out_vld, xfer_vld}), 0);
    rst_n = 1'b1;
    tick();
    chk({nom_vld, out_vld, xfer_vld} == '0, "R1", "outputs after reset", int'(nom_vld), 0);

    // R2: round-robin within port 0, all VCs to output 1
    tag = "R2";
    req[3:0] = 4'hF;
    for (int v = 0; v < 4; v++) route[v*3 +: 3] = 3'd1;
    tick(); chk(nvc(0) == 0, "R2", "first nominee", nvc(0), 0);
    tick(); chk(nvc(0) == 1, "R2", "second nominee", nvc(0), 1);
    tick(); tick();
    chk(nvc(0) == 3, "R2", "fourth nominee", nvc(0), 3);
    req = '0; tick();

    // R9: three ports compete for output 3
    tag = "R9";
    req[0] = 1; req[4] = 1; req[8] = 1;
    route[0 +: 3] = 3'd3; route[12 +: 3] = 3'd3; route[24 +: 3] = 3'd3;
    tick(); chk(out_src[9 +: 3] == 3'd0, "R9", "first winner", int'(out_src[9 +: 3]), 0);
    tick(); chk(out_src[9 +: 3] == 3'd1, "R9", "second winner", int'(out_src[9 +: 3]), 1);
    tick(); chk(out_src[9 +: 3] == 3'd2, "R9", "third winner", int'(out_src[9 +: 3]), 2);
    req = '0; tick();

    // R6, R4, R3: bypass of port 1, default VC 0
    tag = "R4";
    aflt[1] = 1; req[4] = 1; req[6] = 1;
    route[12 +: 3] = 3'd0; route[18 +: 3] = 3'd0;
    tick(); chk(nvc(1) == 2, "R6", "flag not yet in force", nvc(1), 2);
    tick(); chk(nvc(1) == 0, "R4", "default nominee", nvc(1), 0);
    dcfg[3:2] = 2'd3;
    tick(); chk(nom_vld[1] && nvc(1) == 0, "R3", "default frozen", nvc(1), 0);

    // R5: default empty, transfer from VC1
    tag = "R5";
    req = '0; req[5] = 1; req[7] = 1;
    tick();
    chk(xfer_vld[1] && xfer_src[3:2] == 2'd1 && xfer_dst[3:2] == 2'd0, "R5",
        "transfer lowest into default", int'(xfer_src[3:2]), 1);
    chk(!nom_vld[1], "R5", "no nominee during transfer", int'(nom_vld[1]), 0);
    req = '0; aflt = '0; tick(); tick();

    // R7: port 0 line fails, partner line carries it
    tag = "R7";
    lflt[0] = 1; req[0] = 1; req[4] = 1;
    route[0 +: 3] = 3'd2; route[12 +: 3] = 3'd4;
    tick(); chk(nom_vld[0], "R6", "line flag not yet in force", int'(nom_vld[0]), 1);
    tick(); chk(!nom_vld[0] && nom_vld[1], "R7", "partner keeps own line", int'(nom_vld[1:0]), 2);
    req[4] = 0;
    tick(); chk(nom_vld[0] && gnt_vld[0], "R7", "carried on partner line", int'(nom_vld[0]), 1);

    // R8: local multiplexer
    tag = "R8";
    lflt = 5'b00011; req[16] = 1; route[48 +: 3] = 3'd1;
    tick(); tick();
    chk(nom_vld[4] && !nom_vld[0], "R8", "local own first", int'(nom_vld), 16);
    req[16] = 0;
    tick(); chk(nom_vld[0], "R8", "pair spill on local", int'(nom_vld[0]), 1);
    lflt = 5'b01111; req[8] = 1; route[24 +: 3] = 3'd3;
    tick(); tick();
    chk(nom_vld[0] && !nom_vld[2], "R8", "pair 0/1 precedes pair 2/3", int'(nom_vld), 1);
    lflt = 5'b11111;
    tick(); tick();
    chk(nom_vld == '0, "R8", "dead local line", int'(nom_vld), 0);
    req = '0; lflt = '0; tick(); tick();

    // mixed random traffic against the reference model
    tag = "R2";
    for (int i = 0; i < 600; i++) begin
      req = 20'($urandom);
      for (int j = 0; j < 20; j++) route[j*3 +: 3] = 3'($urandom_range(0, 5));
      dcfg = 10'($urandom);
      if ($urandom_range(0, 15) == 0) aflt = 5'($urandom);
      if ($urandom_range(0, 15) == 0) lflt = 5'($urandom);
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule